// File: doc/BRIEF.md
# Overlapping 11101 Sequence Recognizer

This block watches a single serial bit that is sampled on every rising clock edge. It raises a one-bit flag whenever the five most recent samples, oldest first, were 1, 1, 1, 0, 1. The flag rises in the cycle after the fifth bit of the pattern is sampled. Because the flag is decoded from the state alone, it stays high for exactly one cycle for each occurrence.

Occurrences may overlap. The final 1 of one occurrence can serve as the first 1 of the next, so the input 1,1,1,0,1,1,1,0,1 produces two flags. A run of three or more 1s counts as the leading "111" of the pattern. Six states hold the partial-match progress. A synchronous reset returns the machine to the idle state.

The block has one bit in and one bit out, with no valid/ready handshake and no back-pressure. A new bit is consumed on every clock edge, and the flag is a plain status output.

Top module: `seq11101_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is idle and `hit` is 0 after that edge. After `rst` is released, a match needs five fresh samples.
- R2: `hit` is 1 in the cycle after an edge that samples the fifth bit of 1,1,1,0,1 (oldest first) on `seq_in`. At all other times it is 0.
- R3: `hit` is never high in two consecutive cycles.
- R4: Overlapping matches are detected. A 1 sampled while `hit` is high counts as the first two 1s of the next pattern, so 1,1,1,0,1,1,1,0,1 yields two pulses.
- R5: Any run of three or more 1s, followed by 0 and then 1, produces a match.
- R6: A 0 sampled before three 1s have been collected restarts the search, and so do two consecutive 0s after a run of 1s. No pulse follows until a complete new pattern arrives.
- R7: `rst` has priority over a completing bit. If the fifth pattern bit is sampled in a cycle where `rst` is high, no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_in | input | 1 | Serial data bit, sampled every edge |
| hit | output | 1 | One-cycle match flag |

## Verification
Two events can land in the same cycle: the pulse for one match and the first bit of the next match. The bench provokes this with back-to-back overlapping patterns and with long random streams biased toward 1s. A cycle-by-cycle model, which keeps a history of the last five samples since reset, judges the output on every clock. A reset can also coincide with the completing bit. The bench raises `rst` on exactly that edge and expects no pulse and a fresh search afterwards.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    S_IDLE = 3'b000,  // nothing useful seen
    S_ONE  = 3'b001,  // one 1
    S_TWO  = 3'b010,  // two 1s
    S_RUN  = 3'b011,  // three or more 1s
    S_GAP  = 3'b100,  // 1s then a 0
    S_HIT  = 3'b101   // full pattern seen
  } rec_state_t;
endpackage

// File: rtl/rec_next.sv
module rec_next
  import rec_pkg::*;
(
  input  rec_state_t cur,
  input  logic       bit_i,
  output rec_state_t nxt
);
  always_comb begin
    nxt = S_IDLE;
    unique case (cur)
      S_IDLE:  nxt = bit_i ? S_ONE : S_IDLE;
      S_ONE:   nxt = bit_i ? S_TWO : S_IDLE;
      S_TWO:   nxt = bit_i ? S_RUN : S_IDLE;
      S_RUN:   nxt = bit_i ? S_RUN : S_GAP;
      S_GAP:   nxt = bit_i ? S_HIT : S_IDLE;
      S_HIT:   nxt = bit_i ? S_TWO : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rec_state_reg.sv
module rec_state_reg
  import rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rec_state_t d,
  output rec_state_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= S_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/rec_out_decode.sv
module rec_out_decode
  import rec_pkg::*;
(
  input  rec_state_t cur,
  output logic       flag
);
  assign flag = (cur == S_HIT);
endmodule

// File: rtl/seq11101_detector.sv
module seq11101_detector
  import rec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic seq_in,
  output logic hit
);
  rec_state_t st_q;
  rec_state_t st_d;

  rec_next u_next (
    .cur   (st_q),
    .bit_i (seq_in),
    .nxt   (st_d)
  );

  rec_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (st_d),
    .q   (st_q)
  );

  rec_out_decode u_dec (
    .cur  (st_q),
    .flag (hit)
  );
endmodule

// File: rtl/seq11101_checker.sv
module seq11101_checker (
  input logic       clk,
  input logic       rst,
  input logic       seq_in,
  input logic       hit,
  input logic [2:0] st_q
);
  logic [4:0] hist;
  logic [2:0] seen;
  logic       rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      hist <= '0;
      seen <= '0;
    end else begin
      hist <= {hist[3:0], seq_in};
      if (seen != 3'd5) seen <= seen + 3'd1;
    end
  end

  // R1: the cycle after a reset edge shows no pulse
  always @(negedge clk) begin
    if (rst_q) assert_reset_quiet_R1: assert (hit == 1'b0);
  end

  assert_pattern_R2: assert property (@(posedge clk) disable iff (rst)
    hit == ((seen == 3'd5) && (hist == 5'b11101)));

  assert_tail_bits_R2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(seq_in, 1) && !$past(seq_in, 2)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  assert_overlap_state_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && seq_in) |=> (st_q == 3'b010));
endmodule

bind seq11101_detector seq11101_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .seq_in (seq_in),
  .hit    (hit),
  .st_q   (st_q)
);

// File: tb/tb_seq11101_detector.sv
`timescale 1ns/1ps
module tb_seq11101_detector;
  localparam int HALF = 4;  // 8 ns period, 125 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_in = 1'b0;
  logic hit;

  int checks = 0;
  int failures = 0;
  int hist = 0;   // model history, newest bit in bit 0
  int cnt = 0;    // samples since reset
  int hits_seen = 0;
  bit prev_hit = 1'b0;

  always #(HALF) clk = ~clk;

  seq11101_detector dut (
    .clk    (clk),
    .rst    (rst),
    .seq_in (seq_in),
    .hit    (hit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: hit=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one bit, clock it, update the model, compare
  task automatic step(input logic b, input logic r, input string tag);
    logic exp;
    seq_in = b;
    rst = r;
    @(posedge clk);
    #1;
    if (r) begin
      hist = 0;
      cnt = 0;
    end else begin
      hist = ((hist << 1) | int'(b)) & 31;
      if (cnt < 5) cnt++;
    end
    exp = (cnt == 5) && (hist == 5'b11101);
    check(tag, hit, exp);
    if (hit && prev_hit) check("R3", 1'b1, 1'b0);
    prev_hit = hit;
    if (hit) hits_seen++;
    @(negedge clk);
  endtask

  task automatic stream(input logic [31:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b0, tag);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    failures++;
    $display("FAIL watchdog: hit=%0b expected=done", hit);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h0;
    @(negedge clk);
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");
    check("R1", hit, 1'b0);

    // sample stream, pulses after the 13th and 17th bits
    h0 = hits_seen;
    stream(32'b100111001110111010111, 21, "R2");
    checks++;
    if (hits_seen - h0 != 2) begin
      failures++;
      $display("FAIL R2: pulses=%0d expected=2", hits_seen - h0);
    end

    // back-to-back overlap
    step(1'b0, 1'b1, "R1");
    h0 = hits_seen;
    stream(32'b111011101, 9, "R4");
    checks++;
    if (hits_seen - h0 != 2) begin
      failures++;
      $display("FAIL R4: pulses=%0d expected=2", hits_seen - h0);
    end

    // long run of 1s
    stream(32'b0011111111101, 13, "R5");
    // restarts on early zeros and on double zero
    stream(32'b110110101001101, 15, "R6");
    stream(32'b1110010100, 10, "R6");

    // reset on the completing bit
    stream(32'b1110, 4, "R7");
    step(1'b1, 1'b1, "R7");
    check("R7", hit, 1'b0);
    stream(32'b101, 3, "R1");

    // reset after partial progress: needs five fresh bits
    stream(32'b111, 3, "R1");
    step(1'b0, 1'b1, "R1");
    stream(32'b01, 2, "R1");

    // random streams biased toward 1
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 500) == 0, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule